// File: doc/BRIEF.md
# Dual-Mode Timer with Buffered High Byte

This block is a timer/counter on an 8-bit register bus. A mode bit picks one of two personalities. In the narrow mode the low counter byte counts up to a programmable top value and clears. The register at the high-byte address is a pending period that becomes active only when a match ends the current period. In the wide mode the two bytes form one 16-bit up-counter. The high byte goes through a buffer, so that software on the byte bus can read and write a coherent 16-bit value.

Counting is driven by a single-cycle enable input. That input passes through a power-of-two prescaler with a 15-bit count before it reaches the counter. Each match (narrow mode) or rollover (wide mode) produces a one-cycle pulse on an output pin. The same event feeds a postscaler, and the postscaler sets a sticky interrupt flag that software clears by writing 0.

Register map, selected by `busAddr`:
- 0: counter low byte.
- 1: high-byte buffer.
- 2: configuration. Bit 0 is the mode: 0 for narrow, 1 for wide. Bit 1 is the run enable. Bits 7:4 are the prescale select. Bits 3:2 are stored and read back.
- 3: postscale. Bits 3:0 hold n. Bits 6:4 are stored. Bit 7 is the flag.

Top module: `dual_mode_timer`

## Requirements
- R1: Reset clears every register, the counter, the prescaler, the postscaler, the pulse and the flag. All four addresses then read 0x00.
- R2: In narrow mode (address 2, bit 0 = 0), each counter step compares the low byte with the active period P. If they are equal, the low byte clears to 0. Otherwise it increments. A full period is therefore P+1 steps.
- R3: A write to address 1 stores a pending period, and reading address 1 returns it. In narrow mode the pending value becomes the active period only on a match step. The period in progress ends on its old value.
- R4: A step that is a match (narrow mode) or a 0xFFFF-to-0x0000 rollover (wide mode) drives `pulseOut` high for exactly the next clock cycle. `pulseOut` is low when no step occurred in the previous cycle.
- R5: In wide mode (address 2, bit 0 = 1), each step increments the 16-bit count {high, low}. Only the step from 0xFFFF to 0x0000 is an event.
- R6: In wide mode, a bus read of address 0 (`busRd` high) copies the live high byte into the buffer. Later reads of address 1 return that copy even after the counter moves on.
- R7: In wide mode, a write to address 1 changes only the buffer. A write to address 0 loads the low byte and, in the same cycle, copies the buffer into the live high byte.
- R8: With prescale select s (address 2, bits 7:4), the counter steps once per 2^s enable ticks. When the run enable (address 2, bit 1) is 0, ticks have no effect.
- R9: With postscale value n (address 3, bits 3:0), the flag sets on every (n+1)-th event.
- R10: The flag (address 3, bit 7, also driven on `irqOut`) stays set until a write to address 3 with bit 7 = 0. Writing bit 7 = 1 neither sets nor clears it.
- R11: Any register write clears the prescaler count and the postscaler count.
- R12: An enable tick in the same cycle as a register write is discarded, so a value written to address 0 is not stepped in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 2 | Register address |
| busWr | input | 1 | Write strobe, one cycle per write |
| busRd | input | 1 | Read strobe, one cycle per read |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data of the addressed register, combinational |
| tickIn | input | 1 | Count enable tick into the prescaler |
| pulseOut | output | 1 | One-cycle pulse per match or rollover |
| irqOut | output | 1 | Sticky interrupt flag |

## Verification
The embedded assertions check the following on every cycle:
- The active narrow-mode period and the live high byte move only at a match, a carry or a low-byte write.
- The flag is sticky.
- The prescale and postscale counts never pass their limits.
- A pulse always follows a counter step.

The bench shows what the assertions cannot: exact period lengths across many period values, the boundary at which a new period takes effect, 16-bit coherence across reads and writes, the prescale ratio for each select, the postscale ratio for every n, and tick loss on colliding writes.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_LO   = 2'd0,
    ADDR_HI   = 2'd1,
    ADDR_CFG  = 2'd2,
    ADDR_POST = 2'd3
  } regAddr_e;

  // Strobes from control into the datapath
  typedef struct packed {
    logic step;      // prescaled count step
    logic wrLo;      // bus write of the low byte
    logic wrBuf;     // bus write of the high-byte buffer
    logic rdLo;      // bus read of the low byte
    logic wideMode;  // 1: 16-bit counting
  } dpCtrl_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int PRE_W  = 15,
  parameter int POST_W = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic                  busWr,
  input  logic                  busRd,
  input  logic [DATA_W-1:0]     busWdata,
  input  logic                  tickIn,
  input  logic                  evt,
  output dpCtrl_t               dpc,
  output logic [DATA_W-1:0]     cfgRead,
  output logic [DATA_W-1:0]     postRead,
  output logic                  irqFlag
);
  localparam int SEL_W   = $clog2(PRE_W + 1);
  localparam int SEL_LSB = 4;
  localparam int MODE_B  = 0;
  localparam int RUN_B   = 1;
  localparam int FLAG_B  = DATA_W - 1;

  logic [DATA_W-1:0]   cfgReg;
  logic [DATA_W-2:0]   postReg;
  logic [SEL_W-1:0]    preSel;
  logic [POST_W-1:0]   postN;
  logic [POST_W-1:0]   postCnt;
  logic [PRE_W-1:0]    preCnt;
  logic [PRE_W-1:0]    preMask;
  logic [PRE_W:0]      maskWide;
  logic                runEn;
  logic                wrCfg;
  logic                wrPost;
  logic                preHit;
  logic                postHit;

  assign preSel = cfgReg[SEL_LSB +: SEL_W];
  assign runEn  = cfgReg[RUN_B];
  assign postN  = postReg[POST_W-1:0];
  assign wrCfg  = busWr && (busAddr == ADDR_CFG);
  assign wrPost = busWr && (busAddr == ADDR_POST);

  always_comb begin
    maskWide = ((PRE_W+1)'(1) << preSel) - (PRE_W+1)'(1);
    preMask  = maskWide[PRE_W-1:0];
  end

  assign preHit  = tickIn && runEn && (preCnt == preMask);
  assign postHit = evt && (postCnt == postN);

  always_comb begin
    dpc.step     = preHit && !busWr;
    dpc.wrLo     = busWr && (busAddr == ADDR_LO);
    dpc.wrBuf    = busWr && (busAddr == ADDR_HI);
    dpc.rdLo     = busRd && (busAddr == ADDR_LO);
    dpc.wideMode = cfgReg[MODE_B];
  end

  // Configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg  <= '0;
      postReg <= '0;
    end else begin
      if (wrCfg)  cfgReg  <= busWdata;
      if (wrPost) postReg <= busWdata[DATA_W-2:0];
    end
  end

  // Prescaler
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                preCnt <= '0;
    else if (busWr)           preCnt <= '0;
    else if (tickIn && runEn) preCnt <= preHit ? '0 : preCnt + 1'b1;
  end

  // Postscaler and sticky flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      postCnt <= '0;
      irqFlag <= 1'b0;
    end else begin
      if (busWr)    postCnt <= '0;
      else if (evt) postCnt <= postHit ? '0 : postCnt + 1'b1;
      if (postHit && !busWr)               irqFlag <= 1'b1;
      else if (wrPost && !busWdata[FLAG_B]) irqFlag <= 1'b0;
    end
  end

  assign cfgRead  = cfgReg;
  assign postRead = {irqFlag, postReg};

  assert_pre_in_range_R8: assert property (@(posedge clk) disable iff (!rstN)
    preCnt <= preMask);
  assert_post_in_range_R9: assert property (@(posedge clk) disable iff (!rstN)
    postCnt <= postN);
  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlag && !(wrPost && !busWdata[FLAG_B])) |=> irqFlag);
  assert_write_drops_tick_R12: assert property (@(posedge clk) disable iff (!rstN)
    busWr |-> !dpc.step);
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpCtrl_t       dpc,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] cntLo,
  output logic [DW-1:0] cntHi,
  output logic [DW-1:0] bufReg,
  output logic          evt,
  output logic          pulseOut
);
  logic loMatch;
  logic wideWrap;

  assign loMatch  = (cntLo == cntHi);
  assign wideWrap = (&cntLo) && (&cntHi);
  assign evt      = dpc.step && (dpc.wideMode ? wideWrap : loMatch);

  // Counter bytes; in narrow mode cntHi is the active period
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntLo <= '0;
      cntHi <= '0;
    end else if (dpc.wrLo) begin
      cntLo <= wrData;
      if (dpc.wideMode) cntHi <= bufReg;
    end else if (dpc.step) begin
      if (dpc.wideMode) begin
        {cntHi, cntLo} <= {cntHi, cntLo} + 1'b1;
      end else if (loMatch) begin
        cntLo <= '0;
        cntHi <= bufReg;
      end else begin
        cntLo <= cntLo + 1'b1;
      end
    end
  end

  // High-byte buffer: pending period or coherent high byte
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           bufReg <= '0;
    else if (dpc.wrBuf)                  bufReg <= wrData;
    else if (dpc.rdLo && dpc.wideMode)   bufReg <= cntHi;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pulseOut <= 1'b0;
    else       pulseOut <= evt;
  end

  assert_pulse_after_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    pulseOut |-> $past(dpc.step));
  assert_period_held_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!dpc.wideMode && !evt) |=> $stable(cntHi));
  assert_narrow_clear_R2: assert property (@(posedge clk) disable iff (!rstN)
    (dpc.step && !dpc.wideMode && loMatch) |=> (cntLo == '0));
  assert_high_only_carry_R7: assert property (@(posedge clk) disable iff (!rstN)
    (dpc.wideMode && !dpc.wrLo && !(dpc.step && (&cntLo))) |=> $stable(cntHi));
endmodule

// File: rtl/dual_mode_timer.sv
module dual_mode_timer
  import tmr_pkg::*;
#(
  parameter int PRE_W  = 15,
  parameter int POST_W = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  busAddr,
  input  logic        busWr,
  input  logic        busRd,
  input  logic [7:0]  busWdata,
  output logic [7:0]  busRdata,
  input  logic        tickIn,
  output logic        pulseOut,
  output logic        irqOut
);
  dpCtrl_t           dpc;
  logic              evt;
  logic [DATA_W-1:0] cntLo, cntHi, bufReg, cfgRead, postRead;

  tmr_ctrl #(.PRE_W(PRE_W), .POST_W(POST_W)) uCtrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .tickIn(tickIn), .evt(evt), .dpc(dpc),
    .cfgRead(cfgRead), .postRead(postRead), .irqFlag(irqOut)
  );

  tmr_datapath #(.DW(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .dpc(dpc), .wrData(busWdata),
    .cntLo(cntLo), .cntHi(cntHi), .bufReg(bufReg), .evt(evt), .pulseOut(pulseOut)
  );

  always_comb begin
    unique case (busAddr)
      ADDR_LO:   busRdata = cntLo;
      ADDR_HI:   busRdata = bufReg;
      ADDR_CFG:  busRdata = cfgRead;
      default:   busRdata = postRead;
    endcase
  end
endmodule

// File: tb/sim_dual_mode_timer.sv
module sim_dual_mode_timer;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic busWr = 1'b0, busRd = 1'b0, tickIn = 1'b0;
  logic [7:0] busWdata = 8'h00;
  logic [7:0] busRdata;
  logic pulseOut, irqOut;
  int nChk = 0, nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_mode_timer u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .tickIn(tickIn),
    .pulseOut(pulseOut), .irqOut(irqOut)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(posedge clk); @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    busAddr = a; #1; d = busRdata; busRd = 1'b1;
    @(posedge clk); @(negedge clk);
    busRd = 1'b0;
  endtask

  // One enable tick; afterwards busRdata shows the low byte
  task automatic stepOne();
    busAddr = 2'd0; tickIn = 1'b1;
    @(posedge clk); @(negedge clk);
    tickIn = 1'b0; #1;
  endtask

  task automatic syncPulse();
    for (int i = 0; i < 600; i++) begin
      stepOne();
      if (pulseOut) break;
    end
    chk("R2 sync to match", {31'd0, pulseOut}, 32'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    nFail++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk("R1 reset readback", {24'd0, d}, 32'd0);
    end
    chk("R1 reset irq", {31'd0, irqOut}, 32'd0);
    chk("R1 reset pulse", {31'd0, pulseOut}, 32'd0);

    // R2/R4 narrow mode sweep over several periods
    wr(2'd2, 8'h02);
    rd(2'd2, d);
    chk("R1 cfg readback", {24'd0, d}, 32'h02);
    foreach (sweepP[i]) begin
      wr(2'd1, sweepP[i]);
      syncPulse();
      @(posedge clk); @(negedge clk);
      chk("R4 pulse one cycle", {31'd0, pulseOut}, 32'd0);
      for (int k = 1; k <= 2 * (sweepP[i] + 1); k++) begin
        stepOne();
        chk("R2 low byte", {24'd0, busRdata}, k % (sweepP[i] + 1));
        chk("R4 pulse at match", {31'd0, pulseOut}, {31'd0, (k % (sweepP[i] + 1)) == 0});
      end
    end

    // R3 period change waits for match boundary
    wr(2'd1, 8'd5);
    syncPulse();
    stepOne(); stepOne();
    wr(2'd1, 8'd3);
    rd(2'd1, d);
    chk("R3 pending readback", {24'd0, d}, 32'd3);
    for (int k = 3; k <= 6; k++) begin
      stepOne();
      chk("R3 old period finishes", {24'd0, busRdata}, k % 6);
    end
    for (int k = 1; k <= 8; k++) begin
      stepOne();
      chk("R3 new period", {24'd0, busRdata}, k % 4);
      chk("R3 new period pulse", {31'd0, pulseOut}, {31'd0, (k % 4) == 0});
    end

    // R5/R6/R7 wide mode
    wr(2'd2, 8'h03);
    wr(2'd1, 8'h12);
    wr(2'd0, 8'h34);
    rd(2'd0, d);
    chk("R7 low write", {24'd0, d}, 32'h34);
    rd(2'd1, d);
    chk("R7 high committed with low", {24'd0, d}, 32'h12);
    wr(2'd1, 8'h01);
    wr(2'd0, 8'hFF);
    stepOne();
    chk("R5 carry low", {24'd0, busRdata}, 32'h00);
    chk("R5 no event on carry", {31'd0, pulseOut}, 32'd0);
    rd(2'd0, d);
    for (int k = 0; k < 256; k++) stepOne();
    rd(2'd1, d);
    chk("R6 captured high stays", {24'd0, d}, 32'h02);
    rd(2'd0, d);
    chk("R5 low after 256 steps", {24'd0, d}, 32'h00);
    rd(2'd1, d);
    chk("R6 new capture", {24'd0, d}, 32'h03);
    wr(2'd1, 8'h77);
    rd(2'd0, d);
    rd(2'd1, d);
    chk("R7 buffer write not live", {24'd0, d}, 32'h03);
    wr(2'd3, 8'h00);
    wr(2'd1, 8'hFF);
    wr(2'd0, 8'hFE);
    stepOne();
    chk("R5 FFFF no event", {31'd0, pulseOut}, 32'd0);
    stepOne();
    chk("R5 rollover event", {31'd0, pulseOut}, 32'd1);
    chk("R9 flag on rollover n=0", {31'd0, irqOut}, 32'd1);
    rd(2'd0, d);
    chk("R5 low after rollover", {24'd0, d}, 32'h00);
    rd(2'd1, d);
    chk("R5 high after rollover", {24'd0, d}, 32'h00);
    wr(2'd3, 8'h00);

    // R8 prescaler ratios
    foreach (sweepS[i]) begin
      wr(2'd2, {sweepS[i][3:0], 4'b0011});
      wr(2'd1, 8'h00);
      wr(2'd0, 8'h00);
      n = 0;
      for (int k = 0; k < 40000; k++) begin
        stepOne(); n++;
        if (busRdata != 8'h00) break;
      end
      chk("R8 prescale ratio", n, 32'd1 << sweepS[i]);
    end
    wr(2'd2, 8'h01);
    wr(2'd0, 8'h00);
    for (int k = 0; k < 5; k++) stepOne();
    chk("R8 run disabled", {24'd0, busRdata}, 32'h00);

    // R11 write clears prescaler
    wr(2'd2, 8'h23);
    wr(2'd0, 8'h00);
    for (int k = 0; k < 3; k++) stepOne();
    wr(2'd1, 8'h00);
    for (int k = 0; k < 3; k++) stepOne();
    chk("R11 prescaler cleared by write", {24'd0, busRdata}, 32'h00);
    stepOne();
    chk("R11 prescaler full count", {24'd0, busRdata}, 32'h01);

    // R12 tick during write is lost
    wr(2'd2, 8'h03);
    busAddr = 2'd0; busWdata = 8'h40; busWr = 1'b1; tickIn = 1'b1;
    @(posedge clk); @(negedge clk);
    busWr = 1'b0; tickIn = 1'b0; #1;
    chk("R12 write wins over tick", {24'd0, busRdata}, 32'h40);
    stepOne();
    chk("R12 next tick counts", {24'd0, busRdata}, 32'h41);

    // R9/R10 postscaler sweep, narrow mode with period 0
    wr(2'd2, 8'h02);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h00);
    syncPulse();
    for (int p = 0; p < 16; p++) begin
      wr(2'd3, 8'(p));
      for (int k = 0; k < p; k++) begin
        stepOne();
        chk("R9 flag not yet", {31'd0, irqOut}, 32'd0);
      end
      stepOne();
      chk("R9 flag after n+1 events", {31'd0, irqOut}, 32'd1);
    end
    for (int k = 0; k < 4; k++) stepOne();
    chk("R10 flag sticky", {31'd0, irqOut}, 32'd1);
    wr(2'd3, 8'h8F);
    rd(2'd3, d);
    chk("R10 write one keeps flag", {24'd0, d}, 32'h8F);
    wr(2'd3, 8'h00);
    chk("R10 write zero clears", {31'd0, irqOut}, 32'd0);
    wr(2'd3, 8'h80);
    chk("R10 write one does not set", {31'd0, irqOut}, 32'd0);

    // R11 write clears postscaler
    wr(2'd3, 8'h03);
    stepOne(); stepOne();
    wr(2'd1, 8'h00);
    for (int k = 0; k < 3; k++) stepOne();
    chk("R11 postscaler cleared by write", {31'd0, irqOut}, 32'd0);
    stepOne();
    chk("R11 postscaler full count", {31'd0, irqOut}, 32'd1);

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  logic [7:0] sweepP [7] = '{8'd0, 8'd1, 8'd2, 8'd3, 8'd7, 8'd100, 8'd255};
  int sweepS [7] = '{0, 1, 2, 3, 5, 8, 15};
endmodule